// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block decides when a small microcontroller enters and leaves its two low-power states, suspend and sleep, and why it left. Software issues one control write that both requests the state and arms the wake sources it wants for that stay. The four maskable sources are oscillator failure, clock alarm, port match and comparator rising edge. The reset pin is never masked. All event inputs are asynchronous and are synchronized and edge-detected inside the block.

A wake from a maskable source lets execution resume with state preserved, so no reset is requested. A wake from the reset pin asks for a reset and starts a hold-off window, counted on the always-on clock. During that window a further sleep request is ignored, so the pin reset has time to take effect. A supply-monitor disable bit, when set, turns every reset request into a full power-on reset, and that reset clears the bit again. Cause flags record every source that woke the device and are held until the next accepted low-power request.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset, `pwr_state` is 0 (awake), `wake_cause` is 0, `mon_disable` is 0, and `wake_pulse`, `reset_req` and `reset_por` are low.
- R2: A control write while awake with `ctl_wdata[0]`=1 enters suspend (`pwr_state`=1), and one with `ctl_wdata[1]`=1 enters sleep (`pwr_state`=2); sleep wins when both are set. The same write loads the enables from `ctl_wdata[5:2]` (bit 2 oscillator fail, 3 alarm, 4 port match, 5 comparator).
- R3: In suspend or sleep, a rising edge on an enabled source returns `pwr_state` to 0 with exactly one `wake_pulse` cycle and no `reset_req`.
- R4: A rising edge on a source whose enable is 0 leaves the state unchanged. A comparator edge is also ignored while `two_cell_mode` is 0, even when enabled.
- R5: Enables last for one low-power stay only: they are cleared on wake, and a later entry written with enables 0 cannot be ended by a maskable source.
- R6: A falling edge on `rst_pin_n` always wakes the block from suspend or sleep, sets cause bit 4 and gives one `reset_req` cycle. A falling edge while awake also gives one `reset_req` cycle.
- R7: For `HOLD_CYC` cycles after a reset-pin wake, a sleep request is ignored and `pwr_state` stays 0. After the window, a sleep request is accepted.
- R8: A `reset_req` cycle carries `reset_por`=1 exactly when `mon_disable` was 1. `mon_disable` then returns to 0. `mon_disable` is written from `ctl_wdata[6]` by any control write while awake.
- R9: `wake_cause` bits are 0 oscillator fail, 1 alarm, 2 port match, 3 comparator, 4 reset pin. Sources that wake in the same cycle all set their bits. The bits hold until the next accepted low-power write, which clears them.
- R10: Event inputs are edge-triggered: a source already held high when sleep is entered does not wake it, and each edge yields a single internal event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control write data: request bits, wake enables, monitor disable |
| two_cell_mode | input | 1 | Supply configured for two cells; allows comparator wake |
| ev_osc_fail | input | 1 | Asynchronous oscillator-failure event |
| ev_alarm | input | 1 | Asynchronous clock-alarm event |
| ev_port_match | input | 1 | Asynchronous port-match event |
| ev_cmp_rise | input | 1 | Asynchronous comparator output |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| pwr_state | output | 2 | 0 awake, 1 suspend, 2 sleep |
| wake_pulse | output | 1 | One-cycle pulse on each wake |
| reset_req | output | 1 | One-cycle reset request from a reset-pin falling edge |
| reset_por | output | 1 | The reset request is escalated to a power-on reset |
| wake_cause | output | 5 | Held wake-cause flags |
| mon_disable | output | 1 | Supply-monitor disable bit |

## Verification
The bench builds the block with `HOLD_CYC` set to 40 and `SYNC_STAGES` left at 2. The short window lets one run show a sleep request refused inside the hold-off and the same request accepted after it. It also lets the run move on to the comparator, multi-source and escalation cases without long idle stretches. The two-stage synchronizer keeps wake latency short, so every pulse count is taken in a window of a few cycles.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
   typedef enum logic [1:0] {
      PS_AWAKE   = 2'd0,
      PS_SUSPEND = 2'd1,
      PS_SLEEP   = 2'd2
   } pwr_state_e;

   localparam int N_MASK    = 4;
   localparam int N_CAUSE   = N_MASK + 1;
   localparam int CTL_W     = 7;
   localparam int WF_SUSP   = 0;
   localparam int WF_SLEEP  = 1;
   localparam int WF_EN_LO  = 2;
   localparam int WF_MONDIS = WF_EN_LO + N_MASK;
   localparam int SRC_CMP   = 3;
   localparam int CAUSE_PIN = N_MASK;
endpackage

// File: rtl/wake_edge_sync.sv
module wake_edge_sync #(
   parameter int   WIDTH       = 4,
   parameter int   STAGES      = 2,
   parameter logic DETECT_FALL = 1'b0,
   parameter logic RESET_VAL   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] edge_pulse
);
   localparam int CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("wake_edge_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [CHAIN-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {CHAIN{RESET_VAL}};
         else        chain_q <= {chain_q[CHAIN-2:0], async_in[i]};
      end

      if (DETECT_FALL) begin : g_fall
         assign edge_pulse[i] = !chain_q[CHAIN-2] && chain_q[CHAIN-1];
      end else begin : g_rise
         assign edge_pulse[i] = chain_q[CHAIN-2] && !chain_q[CHAIN-1];
      end

      a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
         edge_pulse[i] |=> !edge_pulse[i]);
   end
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
   parameter int HOLD_CYC = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("holdoff_timer: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= LOAD;
      else if (cnt_q != 0) cnt_q <= cnt_q - CW'(1);
   end

   assign busy = (cnt_q != '0);

   a_r7_window_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt_q == $past(cnt_q) - CW'(1)));
   a_r7_start_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
   import pwr_wake_pkg::*;
#(
   parameter int HOLD_CYC    = 4000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             two_cell_mode,
   input  logic             ev_osc_fail,
   input  logic             ev_alarm,
   input  logic             ev_port_match,
   input  logic             ev_cmp_rise,
   input  logic             rst_pin_n,
   output logic [1:0]       pwr_state,
   output logic             wake_pulse,
   output logic             reset_req,
   output logic             reset_por,
   output logic [N_CAUSE-1:0] wake_cause,
   output logic             mon_disable
);
   pwr_state_e          state_q;
   logic [N_MASK-1:0]   en_q;
   logic [N_CAUSE-1:0]  cause_q;
   logic                mon_q;
   logic [N_MASK-1:0]   rise_ev;
   logic [0:0]          pin_ev;
   logic                pin_fall;
   logic                hold_busy;
   logic [N_MASK-1:0]   src_gate;
   logic [N_MASK-1:0]   hits;
   logic                lp_active, wake_now, pin_wake;
   logic                want_sleep, want_susp, sleep_ok, accept;
   pwr_state_e          target;

   wake_edge_sync #(
      .WIDTH(N_MASK), .STAGES(SYNC_STAGES), .DETECT_FALL(1'b0), .RESET_VAL(1'b0)
   ) u_src_sync (
      .clk(clk), .rst_n(rst_n),
      .async_in({ev_cmp_rise, ev_port_match, ev_alarm, ev_osc_fail}),
      .edge_pulse(rise_ev)
   );

   wake_edge_sync #(
      .WIDTH(1), .STAGES(SYNC_STAGES), .DETECT_FALL(1'b1), .RESET_VAL(1'b1)
   ) u_pin_sync (
      .clk(clk), .rst_n(rst_n),
      .async_in(rst_pin_n),
      .edge_pulse(pin_ev)
   );
   assign pin_fall = pin_ev[0];

   holdoff_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(pin_wake), .busy(hold_busy)
   );

   always_comb begin
      src_gate          = '1;
      src_gate[SRC_CMP] = two_cell_mode;
   end

   assign lp_active  = (state_q != PS_AWAKE);
   assign hits       = rise_ev & en_q & src_gate;
   assign pin_wake   = lp_active && pin_fall;
   assign wake_now   = lp_active && ((|hits) || pin_fall);
   assign want_sleep = ctl_wr && ctl_wdata[WF_SLEEP];
   assign want_susp  = ctl_wr && ctl_wdata[WF_SUSP];
   assign sleep_ok   = want_sleep && !hold_busy;
   assign accept     = !lp_active && (sleep_ok || want_susp);
   assign target     = sleep_ok ? PS_SLEEP : PS_SUSPEND;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PS_AWAKE;
         en_q       <= '0;
         cause_q    <= '0;
         mon_q      <= 1'b0;
         wake_pulse <= 1'b0;
         reset_req  <= 1'b0;
         reset_por  <= 1'b0;
      end else begin
         wake_pulse <= wake_now;
         reset_req  <= pin_fall;
         reset_por  <= pin_fall && mon_q;
         if (wake_now) begin
            state_q <= PS_AWAKE;
            en_q    <= '0;
            cause_q <= cause_q | {pin_fall, hits};
         end else if (accept) begin
            state_q <= target;
            en_q    <= ctl_wdata[WF_EN_LO +: N_MASK];
            cause_q <= '0;
         end
         if (pin_fall)                     mon_q <= 1'b0;
         else if (ctl_wr && !lp_active)    mon_q <= ctl_wdata[WF_MONDIS];
      end
   end

   assign pwr_state   = state_q;
   assign wake_cause  = cause_q;
   assign mon_disable = mon_q;

   a_r7_holdoff_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_busy && want_sleep && !lp_active) |=> (state_q != PS_SLEEP));
   a_r4_cmp_needs_two_cell: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_active && !two_cell_mode && rise_ev == 4'b1000 && !pin_fall) |=> $stable(state_q));
   a_r3_no_reset_on_source_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_active && !pin_fall) |=> !reset_req);
   a_r6_pin_always_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      pin_wake |=> (state_q == PS_AWAKE && reset_req && cause_q[CAUSE_PIN]));
   a_r8_por_rides_reset: assert property (@(posedge clk) disable iff (!rst_n)
      reset_por |-> reset_req);
   a_r8_por_clears_monitor_bit: assert property (@(posedge clk) disable iff (!rst_n)
      reset_por |-> !mon_q);
   a_r5_enables_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      wake_now |=> (en_q == '0));
   a_r3_wake_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
endmodule

// File: tb/tb_pwr_wake_ctl.sv
module tb_pwr_wake_ctl;
   localparam int HOLD = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [6:0] ctl_wdata = '0;
   logic       two_cell_mode = 1'b0;
   logic       ev_osc_fail = 1'b0, ev_alarm = 1'b0, ev_port_match = 1'b0, ev_cmp_rise = 1'b0;
   logic       rst_pin_n = 1'b1;
   logic [1:0] pwr_state;
   logic       wake_pulse, reset_req, reset_por, mon_disable;
   logic [4:0] wake_cause;

   int checks = 0;
   int fails = 0;
   int n_wake, n_rst, n_por;
   bit done = 0;

   always #2 clk = ~clk;

   pwr_wake_ctl #(.HOLD_CYC(HOLD), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .two_cell_mode(two_cell_mode), .ev_osc_fail(ev_osc_fail), .ev_alarm(ev_alarm),
      .ev_port_match(ev_port_match), .ev_cmp_rise(ev_cmp_rise), .rst_pin_n(rst_pin_n),
      .pwr_state(pwr_state), .wake_pulse(wake_pulse), .reset_req(reset_req),
      .reset_por(reset_por), .wake_cause(wake_cause), .mon_disable(mon_disable)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic watch(input int n);
      n_wake = 0; n_rst = 0; n_por = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         n_wake += int'(wake_pulse);
         n_rst  += int'(reset_req);
         n_por  += int'(reset_por);
      end
   endtask

   task automatic ctl_write(input logic [6:0] d);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0;
      wait_cyc(1);
   endtask

   task automatic pulse_src(input int idx);
      case (idx)
         0: ev_osc_fail = 1'b1;
         1: ev_alarm = 1'b1;
         2: ev_port_match = 1'b1;
         default: ev_cmp_rise = 1'b1;
      endcase
      wait_cyc(3);
      ev_osc_fail = 1'b0; ev_alarm = 1'b0; ev_port_match = 1'b0; ev_cmp_rise = 1'b0;
   endtask

   task automatic pin_drop();
      rst_pin_n = 1'b0;
      wait_cyc(3);
      rst_pin_n = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 state", pwr_state, 0);
      chk("R1 cause", wake_cause, 0);
      chk("R1 mon", mon_disable, 0);
      chk("R1 pulses", {wake_pulse, reset_req, reset_por}, 0);
   endtask

   task automatic t_enabled_wake();
      ctl_write(7'b0001010);               // sleep, alarm enabled
      chk("R2 enter sleep", pwr_state, 2);
      ctl_write(7'b0000001);               // write while asleep is ignored
      chk("R2 write in sleep ignored", pwr_state, 2);
      fork pulse_src(1); watch(10); join
      chk("R3 state", pwr_state, 0);
      chk("R3 wake pulses", n_wake, 1);
      chk("R3 no reset", n_rst, 0);
      chk("R9 cause alarm", wake_cause, 5'b00010);
   endtask

   task automatic t_disabled_source();
      ctl_write(7'b0000101);               // suspend, osc enabled
      chk("R2 enter suspend", pwr_state, 1);
      chk("R9 cause cleared on entry", wake_cause, 0);
      pulse_src(2);
      wait_cyc(6);
      chk("R4 masked port ignored", pwr_state, 1);
      pulse_src(0);
      wait_cyc(6);
      chk("R3 osc wake", pwr_state, 0);
      chk("R9 cause osc", wake_cause, 5'b00001);
   endtask

   task automatic t_one_shot();
      ctl_write(7'b0000001);               // suspend, no enables
      pulse_src(0);
      wait_cyc(6);
      chk("R5 enables not kept", pwr_state, 1);
      fork pin_drop(); watch(10); join
      chk("R6 pin wakes suspend", pwr_state, 0);
      chk("R6 reset request", n_rst, 1);
      chk("R6 pin cause", wake_cause, 5'b10000);
      wait_cyc(HOLD + 5);
   endtask

   task automatic t_comparator();
      two_cell_mode = 1'b0;
      ctl_write(7'b0100010);               // sleep, comparator enabled
      pulse_src(3);
      wait_cyc(6);
      chk("R4 comparator one-cell ignored", pwr_state, 2);
      two_cell_mode = 1'b1;
      pulse_src(3);
      wait_cyc(6);
      chk("R4 comparator two-cell wakes", pwr_state, 0);
      chk("R9 cause comparator", wake_cause, 5'b01000);
   endtask

   task automatic t_multi();
      ctl_write(7'b0010110);               // sleep, osc and port enabled
      ev_osc_fail = 1'b1; ev_port_match = 1'b1;
      wait_cyc(3);
      ev_osc_fail = 1'b0; ev_port_match = 1'b0;
      wait_cyc(6);
      chk("R9 simultaneous causes", wake_cause, 5'b00101);
      wait_cyc(10);
      chk("R9 causes held", wake_cause, 5'b00101);
   endtask

   task automatic t_holdoff();
      ctl_write(7'b0000010);               // sleep, no enables
      fork pin_drop(); watch(10); join
      chk("R6 pin wakes sleep", pwr_state, 0);
      chk("R8 no escalation", n_por, 0);
      ctl_write(7'b0000010);
      chk("R7 sleep refused in hold-off", pwr_state, 0);
      wait_cyc(HOLD);
      ctl_write(7'b0000010);
      chk("R7 sleep accepted after hold-off", pwr_state, 2);
      pin_drop();
      wait_cyc(HOLD + 5);
   endtask

   task automatic t_escalation();
      ctl_write(7'b1000000);
      chk("R8 monitor bit written", mon_disable, 1);
      fork pin_drop(); watch(10); join
      chk("R8 reset while awake", n_rst, 1);
      chk("R8 escalated", n_por, 1);
      chk("R8 monitor bit cleared", mon_disable, 0);
      fork pin_drop(); watch(10); join
      chk("R8 plain reset", n_por, 0);
      wait_cyc(HOLD + 5);
   endtask

   task automatic t_level();
      ev_alarm = 1'b1;
      wait_cyc(5);
      ctl_write(7'b0001010);               // sleep with alarm already high
      wait_cyc(8);
      chk("R10 held level no wake", pwr_state, 2);
      ev_alarm = 1'b0;
      pin_drop();
      wait_cyc(6);
      chk("R10 recovered by pin", pwr_state, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      t_reset();
      rst_n = 1'b1;
      wait_cyc(3);
      t_reset();
      t_enabled_wake();
      t_disabled_source();
      t_one_shot();
      t_comparator();
      t_multi();
      t_holdoff();
      t_escalation();
      t_level();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule